// File: doc/BRIEF.md
# Privileged instruction trap filter

This block decides whether a privileged instruction may proceed at the hart's current privilege level and virtualization state. It covers wait-for-interrupt, wait-on-reservation-set without a timeout, the supervisor address-translation fence, the two hypervisor translation fences, and the hypervisor guest loads and stores. Each request carries an instruction class, the current mode, the virtualization flag, a flag that says whether supervisor mode is implemented, and the trap-control status bits. The response is one verdict: allow, illegal-instruction fault, or virtual-instruction fault.

For hypervisor guest loads and stores the response also carries a translation-context index: a 3-bit mode field and a two-stage bit. This index tells the memory path to translate the access through both guest and host stages. The block does not halt the hart and does not flush anything. An allow verdict on wait-for-interrupt means the hart may halt.

Requests and responses are streams with valid/ready handshakes and one register stage between them. A request is accepted when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high when the output stage is empty or when the consumer takes the held response in the same cycle. A response stays on the outputs, unchanged, until `out_ready` takes it. Nothing is dropped and nothing is duplicated.

Top module: `priv_trap_filter`

## Requirements
Encodings used below. Class codes: 0 wait-for-interrupt, 1 wait-on-reservation-set, 2 address-translation fence, 3 hypervisor virtual-address fence, 4 hypervisor guest-physical fence, 5 hypervisor load/store, 6 hypervisor execute-type load, 7 reserved. Mode codes: 0 U, 1 S, 3 M; 2 is never driven. Verdict codes: 0 allow, 1 illegal-instruction, 2 virtual-instruction. Context mode codes: 0 user, 1 supervisor, 2 supervisor with user-page access.

- R1: Class 0 gives illegal when trap-wait is set and the mode is S (or the mode is U with no supervisor mode). It also gives illegal when supervisor mode exists and the mode is U while not virtualized.
- R2: When R1 does not apply, class 0 gives virtual-instruction when virtualized and the mode is U, or the mode is S with the virtual trap-wait bit set. Otherwise it gives allow.
- R3: Class 1 gives virtual-instruction when virtualized, the mode is S or U, virtual trap-wait is set and trap-wait is clear. Otherwise it gives illegal when the mode is not M and trap-wait is set. Otherwise it gives allow.
- R4: Class 2 gives illegal when not virtualized and the mode is U, or when not virtualized in S with trap-VM set. When virtualized it gives virtual-instruction if the mode is U or virtual trap-VM is set. Otherwise it gives allow.
- R5: Classes 3 and 4 give virtual-instruction when virtualized. They are allowed in M and in non-virtualized S. Otherwise they give illegal.
- R6: Class 4 gives illegal in non-virtualized S when trap-VM is set. This check is made before R5.
- R7: Classes 5 and 6 are allowed in M. Otherwise they give virtual-instruction when virtualized, and illegal in U when the hypervisor-user bit is clear. Otherwise they give allow.
- R8: For classes 5 and 6 the context mode is the previous-virtual-privilege bit (0 user, 1 supervisor). It becomes code 2 for class 5 when that bit is 1 and the virtual user-access bit is set. The two-stage bit is 1. For all other classes both fields are 0.
- R9: Every response carries exactly one outcome; verdict code 3 never appears.
- R10: An accepted request's response is valid on the next cycle. A valid response that is not taken holds all its fields stable. `in_ready` equals not `out_valid`, or `out_ready`.
- R11: During and right after reset `out_valid` is 0 and `in_ready` is 1.
- R12: Class 7 always gives illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_cls | input | 3 | Instruction class code |
| in_mode | input | 2 | Current privilege mode |
| in_virt | input | 1 | Hart is virtualized |
| in_has_s | input | 1 | Supervisor mode is implemented |
| in_tw | input | 1 | Trap-wait control |
| in_tvm | input | 1 | Trap-VM control |
| in_vtw | input | 1 | Virtual trap-wait control |
| in_vtvm | input | 1 | Virtual trap-VM control |
| in_hu | input | 1 | Hypervisor guest access allowed from U |
| in_spvp | input | 1 | Previous virtual privilege (0 U, 1 S) |
| in_vsum | input | 1 | Guest supervisor may access user pages |
| out_valid | output | 1 | Response valid |
| out_ready | input | 1 | Consumer takes the response |
| out_verdict | output | 2 | 0 allow, 1 illegal, 2 virtual-instruction |
| out_ctx_mode | output | 3 | Translation-context mode field |
| out_ctx_two_stage | output | 1 | Two-stage translation selected |

## Verification
The bench builds the block with its default package widths: a 3-bit class, a 2-bit mode and a 3-bit context mode field. These widths let the bench sweep every class against every legal mode and all 512 combinations of the nine flag inputs. That sweep reaches each priority boundary of the verdict rules, including the case where a fault is masked by an earlier rule. While the sweep runs, the consumer withholds ready at random. This exercises the hold-while-stalled rule and the accept-while-draining rule on every request.

// File: rtl/ptf_pkg.sv
package ptf_pkg;
  localparam int CLS_W  = 3;
  localparam int MODE_W = 2;
  localparam int CTXM_W = 3;
  localparam int VERD_W = 2;

  typedef enum logic [CLS_W-1:0] {
    OP_WFI    = 3'd0,
    OP_WRS    = 3'd1,
    OP_SFENCE = 3'd2,
    OP_HFV    = 3'd3,
    OP_HFG    = 3'd4,
    OP_HLS    = 3'd5,
    OP_HLX    = 3'd6,
    OP_RSVD   = 3'd7
  } op_e;

  typedef enum logic [MODE_W-1:0] {
    MD_U = 2'd0,
    MD_S = 2'd1,
    MD_R = 2'd2,
    MD_M = 2'd3
  } mode_e;

  typedef enum logic [VERD_W-1:0] {
    VD_ALLOW   = 2'd0,
    VD_ILLEGAL = 2'd1,
    VD_VIRT    = 2'd2
  } verdict_e;

  localparam logic [CTXM_W-1:0] CTX_USER = 3'd0;
  localparam logic [CTXM_W-1:0] CTX_SUP  = 3'd1;
  localparam logic [CTXM_W-1:0] CTX_SUM  = 3'd2;

  typedef struct packed {
    verdict_e          verdict;
    logic [CTXM_W-1:0] ctx_mode;
    logic              two_stage;
  } result_t;
endpackage

// File: rtl/ptf_verdict.sv
module ptf_verdict
  import ptf_pkg::*;
(
  input  op_e      op,
  input  mode_e    mode,
  input  logic     virt,
  input  logic     has_s,
  input  logic     tw,
  input  logic     tvm,
  input  logic     vtw,
  input  logic     vtvm,
  input  logic     hu,
  output verdict_e verdict
);
  logic is_u, is_s, is_m;
  verdict_e hfence_v;

  assign is_u = (mode == MD_U);
  assign is_s = (mode == MD_S);
  assign is_m = (mode == MD_M);

  // shared tail of both hypervisor fences (R5)
  always_comb begin
    if (virt)                 hfence_v = VD_VIRT;
    else if (is_m || is_s)    hfence_v = VD_ALLOW;
    else                      hfence_v = VD_ILLEGAL;
  end

  always_comb begin
    verdict = VD_ILLEGAL;
    unique case (op)
      OP_WFI: begin
        if (((is_s || (!has_s && is_u)) && tw) || (has_s && is_u && !virt))
          verdict = VD_ILLEGAL;
        else if (virt && (is_u || (is_s && vtw)))
          verdict = VD_VIRT;
        else
          verdict = VD_ALLOW;
      end
      OP_WRS: begin
        if (virt && (is_s || is_u) && vtw && !tw)
          verdict = VD_VIRT;
        else if (!is_m && tw)
          verdict = VD_ILLEGAL;
        else
          verdict = VD_ALLOW;
      end
      OP_SFENCE: begin
        if (!virt && (is_u || (is_s && tvm)))
          verdict = VD_ILLEGAL;
        else if (virt && (is_u || vtvm))
          verdict = VD_VIRT;
        else
          verdict = VD_ALLOW;
      end
      OP_HFV: verdict = hfence_v;
      OP_HFG: begin
        if (is_s && !virt && tvm) verdict = VD_ILLEGAL;
        else                      verdict = hfence_v;
      end
      OP_HLS, OP_HLX: begin
        if (is_m)                 verdict = VD_ALLOW;
        else if (virt)            verdict = VD_VIRT;
        else if (is_u && !hu)     verdict = VD_ILLEGAL;
        else                      verdict = VD_ALLOW;
      end
      default: verdict = VD_ILLEGAL;
    endcase
  end
endmodule

// File: rtl/ptf_ctx.sv
module ptf_ctx
  import ptf_pkg::*;
(
  input  op_e               op,
  input  logic              spvp,
  input  logic              vsum,
  output logic [CTXM_W-1:0] ctx_mode,
  output logic              two_stage
);
  logic hyp_access;
  logic exec_type;

  assign hyp_access = (op == OP_HLS) || (op == OP_HLX);
  assign exec_type  = (op == OP_HLX);

  always_comb begin
    ctx_mode  = CTX_USER;
    two_stage = 1'b0;
    if (hyp_access) begin
      two_stage = 1'b1;
      if (!spvp)                   ctx_mode = CTX_USER;
      else if (!exec_type && vsum) ctx_mode = CTX_SUM;
      else                         ctx_mode = CTX_SUP;
    end
  end
endmodule

// File: rtl/ptf_slice.sv
module ptf_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_valid && in_ready) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (out_ready) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/priv_trap_filter.sv
module priv_trap_filter
  import ptf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CLS_W-1:0]  in_cls,
  input  logic [MODE_W-1:0] in_mode,
  input  logic              in_virt,
  input  logic              in_has_s,
  input  logic              in_tw,
  input  logic              in_tvm,
  input  logic              in_vtw,
  input  logic              in_vtvm,
  input  logic              in_hu,
  input  logic              in_spvp,
  input  logic              in_vsum,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VERD_W-1:0] out_verdict,
  output logic [CTXM_W-1:0] out_ctx_mode,
  output logic              out_ctx_two_stage
);
  localparam int RES_W = $bits(result_t);

  op_e      op;
  mode_e    mode;
  verdict_e verdict_c;
  result_t  res_c, res_q;
  logic [RES_W-1:0] res_q_bits;

  assign op   = op_e'(in_cls);
  assign mode = mode_e'(in_mode);

  ptf_verdict u_verdict (
    .op(op), .mode(mode), .virt(in_virt), .has_s(in_has_s),
    .tw(in_tw), .tvm(in_tvm), .vtw(in_vtw), .vtvm(in_vtvm),
    .hu(in_hu), .verdict(verdict_c)
  );

  ptf_ctx u_ctx (
    .op(op), .spvp(in_spvp), .vsum(in_vsum),
    .ctx_mode(res_c.ctx_mode), .two_stage(res_c.two_stage)
  );

  assign res_c.verdict = verdict_c;

  ptf_slice #(.W(RES_W)) u_slice (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(res_c),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(res_q_bits)
  );

  assign res_q             = result_t'(res_q_bits);
  assign out_verdict       = res_q.verdict;
  assign out_ctx_mode      = res_q.ctx_mode;
  assign out_ctx_two_stage = res_q.two_stage;
endmodule

// File: rtl/ptf_checker.sv
module ptf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [2:0] in_cls,
  input logic [1:0] in_mode,
  input logic       in_virt,
  input logic       out_valid,
  input logic       out_ready,
  input logic [1:0] out_verdict,
  input logic [2:0] out_ctx_mode,
  input logic       out_ctx_two_stage
);
  logic acc;
  assign acc = in_valid && in_ready;

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_verdict)
      && $stable(out_ctx_mode) && $stable(out_ctx_two_stage)));

  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_verdict != 2'd3));

  p_hyp_m_allow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_cls == 3'd5 && in_mode == 2'd3) |=> (out_verdict == 2'd0));

  p_hfence_virt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_cls == 3'd3 || in_cls == 3'd4) && in_virt) |=> (out_verdict == 2'd2));

  p_two_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_cls == 3'd5 || in_cls == 3'd6)) |=> out_ctx_two_stage);

  p_reserved_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_cls == 3'd7) |=> (out_verdict == 2'd1));
endmodule

bind priv_trap_filter ptf_checker chk_i (.*);

// File: tb/priv_trap_filter_tb_top.sv
`timescale 1ns/1ps
module priv_trap_filter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [2:0] in_cls = '0;
  logic [1:0] in_mode = '0;
  logic in_virt = 0, in_has_s = 0, in_tw = 0, in_tvm = 0, in_vtw = 0;
  logic in_vtvm = 0, in_hu = 0, in_spvp = 0, in_vsum = 0;
  logic in_ready, out_valid, out_ctx_two_stage;
  logic [1:0] out_verdict;
  logic [2:0] out_ctx_mode;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference pipeline state
  bit m_valid = 0;
  int m_verd = 0, m_ctx = 0, m_two = 0, m_cls = 0;

  always #2 clk = ~clk;

  priv_trap_filter dut_i (.*);

  function automatic int ref_verdict(int c, int md, bit v, bit hs, bit tw, bit tvm,
                                     bit vtw, bit vtvm, bit hu);
    bit u = (md == 0), s = (md == 1), m = (md == 3);
    case (c)
      0: begin
        if (((s || (!hs && u)) && tw) || (hs && u && !v)) return 1;
        if (v && (u || (s && vtw))) return 2;
        return 0;
      end
      1: begin
        if (v && (s || u) && vtw && !tw) return 2;
        if (!m && tw) return 1;
        return 0;
      end
      2: begin
        if (!v && (u || (s && tvm))) return 1;
        if (v && (u || vtvm)) return 2;
        return 0;
      end
      3, 4: begin
        if (c == 4 && s && !v && tvm) return 1;
        if (v) return 2;
        if (m || s) return 0;
        return 1;
      end
      5, 6: begin
        if (m) return 0;
        if (v) return 2;
        if (u && !hu) return 1;
        return 0;
      end
      default: return 1;
    endcase
  endfunction

  function automatic string tag_of(int c);
    case (c)
      0: return "R1 R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R5 R6";
      5, 6: return "R7";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d cls=%0d", tag, act, exp, m_cls);
    end
  endtask

  // one clock cycle, starting and ending at a falling edge
  task automatic step(bit vin, output bit acc);
    bit rdy_exp;
    in_valid  = vin;
    out_ready = ($urandom % 4) != 0;
    #0.5;
    rdy_exp = !m_valid || out_ready;
    chk(in_ready == rdy_exp, "R10 in_ready", in_ready, rdy_exp);
    acc = vin && rdy_exp;
    if (acc) begin
      m_valid = 1;
      m_cls  = in_cls;
      m_verd = ref_verdict(in_cls, in_mode, in_virt, in_has_s, in_tw, in_tvm,
                           in_vtw, in_vtvm, in_hu);
      m_two  = (in_cls == 5 || in_cls == 6);
      m_ctx  = !m_two ? 0 : (!in_spvp ? 0 : ((in_cls == 5 && in_vsum) ? 2 : 1));
    end else if (m_valid && out_ready) begin
      m_valid = 0;
    end
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == m_valid, "R10 out_valid", out_valid, m_valid);
    if (m_valid) begin
      chk(out_verdict != 2'd3, "R9 single outcome", out_verdict, m_verd);
      chk(int'(out_verdict) == m_verd, tag_of(m_cls), out_verdict, m_verd);
      chk(int'(out_ctx_mode) == m_ctx, "R8 ctx mode", out_ctx_mode, m_ctx);
      chk(int'(out_ctx_two_stage) == m_two, "R8 two-stage", out_ctx_two_stage, m_two);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit acc;
    int modes[3] = '{0, 1, 3};
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(out_valid == 1'b0, "R11 out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R11 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R11 in_ready after reset", in_ready, 1);

    for (int c = 0; c < 8; c++) begin
      for (int mi = 0; mi < 3; mi++) begin
        for (int f = 0; f < 512; f++) begin
          in_cls   = 3'(c);
          in_mode  = 2'(modes[mi]);
          in_virt  = f[0]; in_has_s = f[1]; in_tw   = f[2];
          in_tvm   = f[3]; in_vtw   = f[4]; in_vtvm = f[5];
          in_hu    = f[6]; in_spvp  = f[7]; in_vsum = f[8];
          do step(1'b1, acc); while (!acc);
          if (($urandom % 8) == 0) step(1'b0, acc);
        end
      end
    end
    // drain
    repeat (8) step(1'b0, acc);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule